// File: doc/BRIEF.md
# Dual signed multiply-subtract accumulator

This block treats each of two 32-bit operands as a pair of signed 16-bit halves. It forms two signed 16x16 products: low half by low half, and high half by high half. It subtracts the high product from the low product and adds a signed 32-bit addend. The low 32 bits of that full-precision sum are returned. A swap control rotates the second operand by 16 bits before the multiply, so the products become low-by-high and high-by-low.

An addend select field with every bit set picks the non-accumulating form, which uses an addend of zero. A sticky overflow flag is set whenever the full sum does not fit in signed 32 bits. The flag stays set until it is cleared through a dedicated input. Results are captured on the clock edge where the input valid is high, and an output valid follows one cycle later.

Top module: `dsm_mul_sub_acc`

## Requirements
- R1: While rst is high at a rising edge, result, out_valid and q_flag are 0 after that edge.
- R2: With swap = 0, an accepted operation yields result = low 32 bits of (N[15:0]*M[15:0] − N[31:16]*M[31:16] + A). All halves are signed two's complement, and A is sign-extended.
- R3: With swap = 1, M is first rotated right by 16 bits. The result is then the low 32 bits of (N[15:0]*M[31:16] − N[31:16]*M[15:0] + A).
- R4: When acc_idx equals 4'hF, the addend is zero and op_a has no effect on result or q_flag.
- R5: q_flag becomes 1 after an accepted operation whose full-precision sum lies outside [−2^31, 2^31−1]. Once set, it stays 1 until cleared, including across later operations that do not overflow.
- R6: q_clear high at a rising edge makes q_flag 0 after that edge, even if an overflowing operation is accepted on the same edge.
- R7: out_valid is 1 in the cycle after in_valid is sampled high and 0 otherwise. While in_valid is low, result holds its last value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Accept the operands on this edge |
| op_n | input | 32 | First operand, two signed halves |
| op_m | input | 32 | Second operand, two signed halves |
| op_a | input | 32 | Signed accumulate addend |
| acc_idx | input | 4 | Addend select; 4'hF selects no accumulation |
| swap | input | 1 | Exchange the halves of op_m before multiplying |
| q_clear | input | 1 | Clear the sticky overflow flag |
| out_valid | output | 1 | Result registered from the previous accepted operation |
| result | output | 32 | Low 32 bits of the full-precision sum |
| q_flag | output | 1 | Sticky accumulate overflow flag |

## Verification
Overflow needs the product difference and the addend to land near the signed 32-bit limits together. Uniform random operands almost never reach that. The stimulus therefore draws each half from a corner set (−32768, 32767, −1, 0) with high probability, and the addend from the extreme values, in both swap settings. A directed case also accepts an overflowing operation on the same edge as q_clear, to show the clear wins.

// File: rtl/dsm_pkg.sv
package dsm_pkg;
    localparam int HALF_W  = 16;
    localparam int DATA_W  = 2 * HALF_W;
    localparam int PROD_W  = 2 * HALF_W;
    localparam int SUM_W   = DATA_W + 2;
    localparam int IDX_W   = 4;
    localparam int LANES   = 2;
    localparam logic [IDX_W-1:0] NO_ACC_IDX = '1;

    typedef struct packed {
        logic signed [HALF_W-1:0] hi;
        logic signed [HALF_W-1:0] lo;
    } halves_t;

    typedef struct packed {
        logic [DATA_W-1:0] value;
        logic              ovf;
    } acc_out_t;

    function automatic halves_t swap_halves(input halves_t x);
        halves_t r;
        r.hi = x.lo;
        r.lo = x.hi;
        return r;
    endfunction
endpackage

// File: rtl/dsm_operand_prep.sv
module dsm_operand_prep
    import dsm_pkg::*;
(
    input  halves_t m_in,
    input  logic    swap,
    output halves_t m_out
);
    always_comb begin
        if (swap) m_out = swap_halves(m_in);
        else      m_out = m_in;
    end
endmodule

// File: rtl/dsm_mul_pair.sv
module dsm_mul_pair
    import dsm_pkg::*;
(
    input  halves_t                        a,
    input  halves_t                        b,
    output logic [LANES-1:0][PROD_W-1:0]   prod
);
    for (genvar g = 0; g < LANES; g++) begin : g_lane
        logic signed [HALF_W-1:0] x;
        logic signed [HALF_W-1:0] y;
        logic signed [PROD_W-1:0] p;
        assign x = (g == 0) ? a.lo : a.hi;
        assign y = (g == 0) ? b.lo : b.hi;
        assign p = x * y;
        assign prod[g] = p;
    end
endmodule

// File: rtl/dsm_accum.sv
module dsm_accum
    import dsm_pkg::*;
(
    input  logic [LANES-1:0][PROD_W-1:0] prod,
    input  logic [DATA_W-1:0]            addend,
    input  logic                         use_acc,
    output acc_out_t                     out
);
    logic signed [SUM_W-1:0] p_lo;
    logic signed [SUM_W-1:0] p_hi;
    logic signed [SUM_W-1:0] add_x;
    logic signed [SUM_W-1:0] sum;
    logic [SUM_W-DATA_W:0]   top_bits;

    always_comb begin
        p_lo  = SUM_W'($signed(prod[0]));
        p_hi  = SUM_W'($signed(prod[1]));
        add_x = use_acc ? SUM_W'($signed(addend)) : '0;
        sum   = (p_lo - p_hi) + add_x;
        top_bits  = sum[SUM_W-1:DATA_W-1];
        out.value = sum[DATA_W-1:0];
        out.ovf   = (top_bits != '0) && (top_bits != '1);
    end
endmodule

// File: rtl/dsm_mul_sub_acc.sv
module dsm_mul_sub_acc
    import dsm_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              in_valid,
    input  logic [DATA_W-1:0] op_n,
    input  logic [DATA_W-1:0] op_m,
    input  logic [DATA_W-1:0] op_a,
    input  logic [IDX_W-1:0]  acc_idx,
    input  logic              swap,
    input  logic              q_clear,
    output logic              out_valid,
    output logic [DATA_W-1:0] result,
    output logic              q_flag
);
    halves_t                      n_h;
    halves_t                      m_h;
    halves_t                      m_sel;
    logic [LANES-1:0][PROD_W-1:0] prod;
    acc_out_t                     acc;
    logic                         use_acc;

    assign n_h     = halves_t'(op_n);
    assign m_h     = halves_t'(op_m);
    assign use_acc = (acc_idx != NO_ACC_IDX);

    dsm_operand_prep u_prep (.m_in(m_h), .swap(swap), .m_out(m_sel));
    dsm_mul_pair     u_mul  (.a(n_h), .b(m_sel), .prod(prod));
    dsm_accum        u_acc  (.prod(prod), .addend(op_a), .use_acc(use_acc), .out(acc));

    always_ff @(posedge clk) begin
        if (rst) begin
            out_valid <= 1'b0;
            result    <= '0;
            q_flag    <= 1'b0;
        end else begin
            out_valid <= in_valid;
            if (in_valid) result <= acc.value;
            if (q_clear)                    q_flag <= 1'b0;
            else if (in_valid && acc.ovf)   q_flag <= 1'b1;
        end
    end
endmodule

// File: rtl/dsm_mul_sub_acc_chk.sv
module dsm_mul_sub_acc_chk
    import dsm_pkg::*;
(
    input logic              clk,
    input logic              rst,
    input logic              in_valid,
    input logic [IDX_W-1:0]  acc_idx,
    input logic              q_clear,
    input logic              out_valid,
    input logic [DATA_W-1:0] result,
    input logic              q_flag
);
    p_valid_follows_r7: assert property (@(posedge clk) disable iff (rst)
        in_valid |=> out_valid);
    p_valid_drops_r7: assert property (@(posedge clk) disable iff (rst)
        !in_valid |=> !out_valid);
    p_hold_result_r7: assert property (@(posedge clk) disable iff (rst)
        !in_valid |=> $stable(result));
    p_sticky_q_r5: assert property (@(posedge clk) disable iff (rst)
        (q_flag && !q_clear) |=> q_flag);
    p_clear_wins_r6: assert property (@(posedge clk) disable iff (rst)
        q_clear |=> !q_flag);
    p_no_acc_no_ovf_r4: assert property (@(posedge clk) disable iff (rst)
        (in_valid && acc_idx == NO_ACC_IDX && !q_flag) |=> !q_flag);
endmodule

bind dsm_mul_sub_acc dsm_mul_sub_acc_chk u_chk (.*);

// File: tb/dsm_mul_sub_acc_test.sv
`timescale 1ns/1ps
module dsm_mul_sub_acc_test;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        in_valid = 1'b0;
    logic [31:0] op_n = '0, op_m = '0, op_a = '0;
    logic [3:0]  acc_idx = '0;
    logic        swap = 1'b0, q_clear = 1'b0;
    logic        out_valid;
    logic [31:0] result;
    logic        q_flag;

    int checks = 0;
    int errors = 0;
    logic        exp_q = 1'b0;
    logic [31:0] exp_res = '0;

    always #5 clk = ~clk;

    dsm_mul_sub_acc uut (.*);

    function automatic longint full_sum(input logic [31:0] n, input logic [31:0] m,
                                        input logic [31:0] a, input logic [3:0] idx,
                                        input logic sw);
        logic [31:0] mm;
        longint p1, p2, ad;
        mm = sw ? {m[15:0], m[31:16]} : m;
        p1 = longint'($signed(n[15:0])) * longint'($signed(mm[15:0]));
        p2 = longint'($signed(n[31:16])) * longint'($signed(mm[31:16]));
        ad = (idx == 4'hF) ? 64'sd0 : longint'($signed(a));
        return p1 - p2 + ad;
    endfunction

    function automatic logic overflows(input longint s);
        return s != longint'($signed(s[31:0]));
    endfunction

    task automatic check(input string req, input string what, input logic [31:0] act,
                         input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    task automatic run_op(input logic [31:0] n, input logic [31:0] m, input logic [31:0] a,
                          input logic [3:0] idx, input logic sw, input logic clr,
                          input string req);
        longint s;
        @(negedge clk);
        op_n = n; op_m = m; op_a = a; acc_idx = idx; swap = sw; q_clear = clr;
        in_valid = 1'b1;
        s = full_sum(n, m, a, idx, sw);
        exp_res = s[31:0];
        if (clr) exp_q = 1'b0;
        else if (overflows(s)) exp_q = 1'b1;
        @(negedge clk);
        in_valid = 1'b0; q_clear = 1'b0;
        check(req, "result", result, exp_res);
        check("R7", "out_valid", {31'b0, out_valid}, 32'd1);
        check(req, "q_flag", {31'b0, q_flag}, {31'b0, exp_q});
    endtask

    task automatic idle_cycle(input logic clr);
        @(negedge clk);
        in_valid = 1'b0; q_clear = clr;
        op_n = $urandom; op_m = $urandom; op_a = $urandom;
        if (clr) exp_q = 1'b0;
        @(negedge clk);
        q_clear = 1'b0;
        check("R7", "held result", result, exp_res);
        check("R7", "out_valid low", {31'b0, out_valid}, 32'd0);
        check(clr ? "R6" : "R5", "q_flag idle", {31'b0, q_flag}, {31'b0, exp_q});
    endtask

    function automatic logic [15:0] pick_half();
        case ($urandom_range(0, 5))
            0: return 16'h8000;
            1: return 16'h7FFF;
            2: return 16'hFFFF;
            3: return 16'h0000;
            default: return 16'($urandom);
        endcase
    endfunction

    function automatic logic [31:0] pick_acc();
        case ($urandom_range(0, 4))
            0: return 32'h7FFF_FFFF;
            1: return 32'h8000_0000;
            default: return $urandom;
        endcase
    endfunction

    initial begin
        #2_000_000;
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        void'($urandom(32'd1234));
        repeat (3) @(negedge clk);
        check("R1", "result after reset", result, 32'h0);
        check("R1", "out_valid after reset", {31'b0, out_valid}, 32'd0);
        check("R1", "q_flag after reset", {31'b0, q_flag}, 32'd0);
        rst = 1'b0;

        run_op(32'h0003_0002, 32'h0005_0007, 32'd100, 4'h1, 1'b0, 1'b0, "R2");
        run_op(32'h0003_0002, 32'h0005_0007, 32'd100, 4'h1, 1'b1, 1'b0, "R3");
        run_op(32'h8000_8000, 32'h8000_8000, 32'h7FFF_FFFF, 4'h2, 1'b0, 1'b0, "R2");
        run_op(32'h8000_8000, 32'h8000_8000, 32'h8000_0000, 4'h2, 1'b1, 1'b0, "R3");
        run_op(32'h8000_8000, 32'h7FFF_8000, 32'h1234_5678, 4'hF, 1'b0, 1'b0, "R4");
        run_op(32'h8000_8000, 32'h7FFF_8000, 32'h7FFF_FFFF, 4'hF, 1'b0, 1'b0, "R4");
        check("R4", "no flag without addend", {31'b0, q_flag}, 32'd0);
        run_op(32'h8000_8000, 32'h7FFF_8000, 32'h7FFF_FFFF, 4'h3, 1'b0, 1'b0, "R5");
        check("R5", "flag set on overflow", {31'b0, q_flag}, 32'd1);
        run_op(32'h0001_0001, 32'h0001_0001, 32'd5, 4'h3, 1'b0, 1'b0, "R5");
        check("R5", "flag sticky", {31'b0, q_flag}, 32'd1);
        idle_cycle(1'b0);
        idle_cycle(1'b1);
        run_op(32'h8000_8000, 32'h7FFF_8000, 32'h7FFF_FFFF, 4'h3, 1'b0, 1'b1, "R6");
        check("R6", "clear beats set", {31'b0, q_flag}, 32'd0);
        run_op(32'h8000_8000, 32'h8000_7FFF, 32'h8000_0000, 4'h4, 1'b1, 1'b0, "R3");

        for (int i = 0; i < 600; i++) begin
            if ($urandom_range(0, 9) == 0) idle_cycle($urandom_range(0, 1) == 1);
            run_op({pick_half(), pick_half()}, {pick_half(), pick_half()}, pick_acc(),
                   4'($urandom), $urandom_range(0, 1) == 1, $urandom_range(0, 15) == 0,
                   "R2");
        end

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule